// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight-bit status word of an asynchronous serial port. It keeps the flags that say whether the transmit buffer is free, whether a received byte is waiting, and which receive errors occurred. It also keeps the end-of-transmission flag, the multiprocessor bit of the last accepted character, and the multiprocessor bit to be sent. The transmit and receive datapaths report events to it as single-cycle strobes. The processor reads the word and clears flags through a simple strobe interface. The block also captures the received byte into a holding register when a reception is accepted.

Most error and data flags are cleared by a two-step software handshake. The processor must first read the flag while it is 1, and then write 0 to it. A separate arm latch for each clearable bit records that the flag was seen. Any status write drops every arm latch. Accesses to the data buffers also set or clear several flags as a side effect. When a hardware set and a software clear fall in the same cycle, the set wins.

Top module: `serial_flag_reg`

## Requirements
- R1: After synchronous reset the status word `stat` reads 8'h84. The bit layout from bit 7 down to bit 0 is: 7 tx-buffer-empty, 6 rx-buffer-full, 5 overrun, 4 framing error, 3 parity error, 2 tx-end, 1 received multiprocessor bit, 0 transmit multiprocessor bit. `rx_buf` reads 0 after reset.
- R2: Bits 7..3 change from software only when a status write carries 0 in that bit and a status read has returned 1 for that bit since the previous status write. In that case the bit clears. A write of 0 without such a read leaves a set bit at 1. A write of 1 never sets a bit.
- R3: Tx-buffer-empty (bit 7) clears on `cpu_wr_txbuf`. It sets on `tx_load` and stays set in every cycle in which `tx_en` is 0.
- R4: Tx-end (bit 2) sets on `tx_last` when bit 7 is 1, and is left unchanged by `tx_last` when bit 7 is 0. It clears on `cpu_wr_txbuf`, and on a software clear of bit 7 under the rule of R2.
- R5: A reception is accepted when `rx_done` is high, bit 6 is 0, `rx_stop` is 1, and no parity error is present. An accepted reception sets bit 6 and loads `rx_data` into `rx_buf`. `cpu_rd_rxbuf` clears bit 6.
- R6: `rx_done` while bit 6 is 1 sets overrun (bit 5). In that case `rx_buf`, bit 6 and bit 1 keep their values.
- R7: `rx_done` with `rx_stop` = 0 while bit 6 is 0 sets framing error (bit 4) and does not set bit 6.
- R8: With `par_en` = 1, `rx_done` while bit 6 is 0 sets parity error (bit 3) and does not set bit 6 when the XOR of `rx_data` and `rx_par` differs from `par_odd` (0 selects even parity, 1 selects odd parity). When they match, the reception is accepted.
- R9: Bit 1 takes `rx_mpb` on every `rx_done` that is not an overrun. Status writes never change bits 2 and 1.
- R10: Bit 0 is an ordinary read/write bit. Every status write loads `cpu_wdata[0]` into it.
- R11: A hardware set of bit 7 in the same cycle as a software clear or a `cpu_wr_txbuf` leaves bit 7 at 1.
- R12: A status write drops all arm latches. A read of 1, then a write of 1, then a write of 0 leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd_stat | input | 1 | Status read strobe |
| cpu_wr_stat | input | 1 | Status write strobe |
| cpu_wdata | input | 8 | Status write data |
| cpu_wr_txbuf | input | 1 | Transmit data register write strobe |
| cpu_rd_rxbuf | input | 1 | Receive data register read strobe |
| tx_en | input | 1 | Transmitter enable |
| tx_load | input | 1 | Byte moved from tx buffer to tx shifter |
| tx_last | input | 1 | Last bit of a character sent |
| rx_done | input | 1 | Reception complete strobe |
| rx_data | input | DATA_W | Received data bits |
| rx_par | input | 1 | Received parity bit |
| rx_stop | input | 1 | Sampled stop bit |
| rx_mpb | input | 1 | Received multiprocessor bit |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | Parity mode, 1 = odd |
| stat | output | 8 | Status word, also the flag levels |
| rx_buf | output | DATA_W | Receive holding register |

## Verification
The bench writes 0 to set flags without a prior read. A design that ignored the arm latch would clear them, and the flags would be lost. It also reads a flag, writes 1 to it, and then writes 0, to show that the arm latch is dropped by any write. A design that kept the latch would clear the flag on the second write. The bench forces a set and a clear into the same cycle. A clear-priority design would drop the tx-buffer-empty event and leave the transmitter stalled. Finally, it receives a byte into a full buffer and checks that the held byte and the multiprocessor bit survive. It also covers even and odd parity, and tx-end while the buffer is still full. A design that overwrote the buffer, or set tx-end too early, would show a wrong byte or a wrong end flag.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int STAT_W   = 8;
  localparam int B_TXE    = 7;
  localparam int B_RXF    = 6;
  localparam int B_OVR    = 5;
  localparam int B_FRM    = 4;
  localparam int B_PAR    = 3;
  localparam int B_TEND   = 2;
  localparam int B_MPR    = 1;
  localparam int B_MPT    = 0;
  localparam int CLR_LO   = 3;
  localparam int CLR_N    = STAT_W - CLR_LO;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h84;
endpackage

// File: rtl/sflag_arm.sv
module sflag_arm #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic         wr,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] flags,
  output logic [N-1:0] clr
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_arm
    always_ff @(posedge clk) begin
      if (rst)                 arm_q[i] <= 1'b0;
      else if (wr)             arm_q[i] <= 1'b0;
      else if (rd && flags[i]) arm_q[i] <= 1'b1;
    end
    assign clr[i] = wr & ~wbits[i] & arm_q[i];

    // R12: a write following a write can never be armed
    a_r12_write_drops_arm: assert property (@(posedge clk) disable iff (rst)
      wr |=> !arm_q[i]);
  end
endmodule

// File: rtl/sflag_tx.sv
module sflag_tx (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic tx_load,
  input  logic tx_last,
  input  logic wr_txbuf,
  input  logic sw_clr_txe,
  output logic txe,
  output logic tend
);
  logic txe_set, txe_clr, tend_set, tend_clr;

  assign txe_set  = ~tx_en | tx_load;
  assign txe_clr  = wr_txbuf | sw_clr_txe;
  assign tend_set = tx_last & txe;
  assign tend_clr = wr_txbuf | sw_clr_txe;

  always_ff @(posedge clk) begin
    if (rst) begin
      txe  <= 1'b1;
      tend <= 1'b1;
    end else begin
      if (txe_set)       txe <= 1'b1;
      else if (txe_clr)  txe <= 1'b0;
      if (tend_set)      tend <= 1'b1;
      else if (tend_clr) tend <= 1'b0;
    end
  end

  a_r3_txe_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> txe);
  a_r3_txe_cleared_by_write: assert property (@(posedge clk) disable iff (rst)
    wr_txbuf && tx_en && !tx_load |=> !txe);
  a_r4_tend_on_last: assert property (@(posedge clk) disable iff (rst)
    tx_last && txe |=> tend);
  a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    tx_load && (wr_txbuf || sw_clr_txe) |=> txe);
endmodule

// File: rtl/sflag_rx.sv
module sflag_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  input  logic              rx_stop,
  input  logic              rx_mpb,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_rxbuf,
  input  logic [3:0]        sw_clr,
  output logic              rxf,
  output logic              ovr,
  output logic              frm,
  output logic              perr,
  output logic              mpr,
  output logic [DATA_W-1:0] rx_buf
);
  logic take, par_bad, ovr_set, frm_set, per_set, good;

  assign take    = rx_done & ~rxf;
  assign par_bad = par_en & ((^{rx_data, rx_par}) != par_odd);
  assign ovr_set = rx_done & rxf;
  assign frm_set = take & ~rx_stop;
  assign per_set = take & par_bad;
  assign good    = take & rx_stop & ~par_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxf    <= 1'b0;
      ovr    <= 1'b0;
      frm    <= 1'b0;
      perr   <= 1'b0;
      mpr    <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (good)                       rxf <= 1'b1;
      else if (rd_rxbuf || sw_clr[3]) rxf <= 1'b0;
      if (ovr_set)        ovr  <= 1'b1;
      else if (sw_clr[2]) ovr  <= 1'b0;
      if (frm_set)        frm  <= 1'b1;
      else if (sw_clr[1]) frm  <= 1'b0;
      if (per_set)        perr <= 1'b1;
      else if (sw_clr[0]) perr <= 1'b0;
      if (take)           mpr  <= rx_mpb;
      if (good)           rx_buf <= rx_data;
    end
  end

  a_r6_overrun_flags: assert property (@(posedge clk) disable iff (rst)
    rx_done && rxf |=> ovr);
  a_r6_overrun_keeps_buf: assert property (@(posedge clk) disable iff (rst)
    rx_done && rxf |=> $stable(rx_buf) && $stable(mpr));
  a_r7_frame_blocks_rxf: assert property (@(posedge clk) disable iff (rst)
    rx_done && !rxf && !rx_stop |=> frm && !rxf);
  a_r5_read_clears_rxf: assert property (@(posedge clk) disable iff (rst)
    rd_rxbuf && !rx_done |=> !rxf);
endmodule

// File: rtl/serial_flag_reg.sv
module serial_flag_reg
  import sflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd_stat,
  input  logic              cpu_wr_stat,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr_txbuf,
  input  logic              cpu_rd_rxbuf,
  input  logic              tx_en,
  input  logic              tx_load,
  input  logic              tx_last,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  input  logic              rx_stop,
  input  logic              rx_mpb,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [7:0]        stat,
  output logic [DATA_W-1:0] rx_buf
);
  logic [CLR_N-1:0] clr;
  logic txe, tend, rxf, ovr, frm, perr, mpr, mpt;

  sflag_arm #(.N(CLR_N)) u_arm (
    .clk(clk), .rst(rst), .rd(cpu_rd_stat), .wr(cpu_wr_stat),
    .wbits(cpu_wdata[STAT_W-1:CLR_LO]), .flags(stat[STAT_W-1:CLR_LO]),
    .clr(clr)
  );

  sflag_tx u_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_load(tx_load),
    .tx_last(tx_last), .wr_txbuf(cpu_wr_txbuf),
    .sw_clr_txe(clr[B_TXE-CLR_LO]), .txe(txe), .tend(tend)
  );

  sflag_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_data(rx_data),
    .rx_par(rx_par), .rx_stop(rx_stop), .rx_mpb(rx_mpb),
    .par_en(par_en), .par_odd(par_odd), .rd_rxbuf(cpu_rd_rxbuf),
    .sw_clr(clr[B_RXF-CLR_LO:0]), .rxf(rxf), .ovr(ovr), .frm(frm),
    .perr(perr), .mpr(mpr), .rx_buf(rx_buf)
  );

  always_ff @(posedge clk) begin
    if (rst)              mpt <= 1'b0;
    else if (cpu_wr_stat) mpt <= cpu_wdata[B_MPT];
  end

  always_comb begin
    stat         = '0;
    stat[B_TXE]  = txe;
    stat[B_RXF]  = rxf;
    stat[B_OVR]  = ovr;
    stat[B_FRM]  = frm;
    stat[B_PAR]  = perr;
    stat[B_TEND] = tend;
    stat[B_MPR]  = mpr;
    stat[B_MPT]  = mpt;
  end

  a_r1_reset_value: assert property (@(posedge clk)
    $past(rst) && !rst |-> stat == STAT_RST);
  a_r2_unarmed_write_holds: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_stat && $past(cpu_wr_stat) && stat[B_OVR] |=> stat[B_OVR]);
  a_r9_write_keeps_ro: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_stat && !rx_done && !tx_last && !cpu_wr_txbuf && !stat[B_TXE]
      |=> $stable(stat[B_MPR]) && $stable(stat[B_TEND]));
  a_r10_mpt_written: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_stat |=> stat[B_MPT] == $past(cpu_wdata[B_MPT]));
endmodule

// File: tb/serial_flag_reg_tb.sv
module serial_flag_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_rd_stat = 0, cpu_wr_stat = 0, cpu_wr_txbuf = 0, cpu_rd_rxbuf = 0;
  logic [7:0] cpu_wdata = 0;
  logic tx_en = 1, tx_load = 0, tx_last = 0;
  logic rx_done = 0, rx_par = 0, rx_stop = 1, rx_mpb = 0, par_en = 0, par_odd = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] stat, rx_buf;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  serial_flag_reg u_dut (
    .clk(clk), .rst(rst), .cpu_rd_stat(cpu_rd_stat), .cpu_wr_stat(cpu_wr_stat),
    .cpu_wdata(cpu_wdata), .cpu_wr_txbuf(cpu_wr_txbuf), .cpu_rd_rxbuf(cpu_rd_rxbuf),
    .tx_en(tx_en), .tx_load(tx_load), .tx_last(tx_last), .rx_done(rx_done),
    .rx_data(rx_data), .rx_par(rx_par), .rx_stop(rx_stop), .rx_mpb(rx_mpb),
    .par_en(par_en), .par_odd(par_odd), .stat(stat), .rx_buf(rx_buf)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd_stat();
    cpu_rd_stat = 1; @(negedge clk); cpu_rd_stat = 0;
  endtask
  task automatic wr_stat(input logic [7:0] v);
    cpu_wr_stat = 1; cpu_wdata = v; @(negedge clk); cpu_wr_stat = 0;
  endtask
  task automatic rx(input logic [7:0] d, input logic p, input logic s, input logic m);
    rx_done = 1; rx_data = d; rx_par = p; rx_stop = s; rx_mpb = m;
    @(negedge clk);
    rx_done = 0; rx_stop = 1;
  endtask

  task automatic t_reset();
    chk("R1 reset status", stat, 8'h84);
    chk("R1 reset rx_buf", rx_buf, 8'h00);
  endtask

  task automatic t_sw_clear();
    wr_stat(8'h00);
    chk("R2 unarmed write of 0 keeps flags", stat, 8'h84);
    wr_stat(8'h03);
    chk("R9 R10 ro bits kept, mpt written", stat, 8'h85);
    rd_stat(); wr_stat(8'hFF); wr_stat(8'h7E);
    chk("R12 write drops arm", stat, 8'h84);
    rd_stat(); wr_stat(8'h7F);
    chk("R2 R4 armed clear of txe and tend, ones ignored", stat, 8'h01);
  endtask

  task automatic t_tx();
    tx_load = 1; @(negedge clk); tx_load = 0;
    chk("R3 tx_load sets txe", stat, 8'h81);
    tx_last = 1; @(negedge clk); tx_last = 0;
    chk("R4 tend on last bit", stat, 8'h85);
    cpu_wr_txbuf = 1; @(negedge clk); cpu_wr_txbuf = 0;
    chk("R3 R4 txbuf write clears", stat, 8'h01);
    tx_last = 1; @(negedge clk); tx_last = 0;
    chk("R4 no tend while buffer full", stat, 8'h01);
    tx_en = 0; @(negedge clk); tx_en = 1;
    chk("R3 disabled sets txe", stat, 8'h81);
  endtask

  task automatic t_race();
    rd_stat();
    tx_load = 1; wr_stat(8'h01); tx_load = 0;
    chk("R11 set beats software clear", stat, 8'h81);
    tx_load = 1; cpu_wr_txbuf = 1; @(negedge clk); tx_load = 0; cpu_wr_txbuf = 0;
    chk("R11 set beats txbuf write", stat, 8'h81);
  endtask

  task automatic t_rx();
    rx(8'h5A, 1'b0, 1'b1, 1'b1);
    chk("R5 rxf set", stat & 8'h42, 8'h42);
    chk("R5 data captured", rx_buf, 8'h5A);
    rx(8'h33, 1'b0, 1'b1, 1'b0);
    chk("R6 overrun flags", stat & 8'h62, 8'h62);
    chk("R6 buffer kept", rx_buf, 8'h5A);
    cpu_rd_rxbuf = 1; @(negedge clk); cpu_rd_rxbuf = 0;
    chk("R5 read clears rxf", stat & 8'h40, 8'h00);
    rd_stat(); wr_stat(8'hDF);
    chk("R2 armed clear of overrun", stat & 8'h20, 8'h00);
  endtask

  task automatic t_err();
    rx(8'h11, 1'b0, 1'b0, 1'b0);
    chk("R7 framing error, no rxf, mpr updated", stat & 8'h52, 8'h10);
    par_en = 1; par_odd = 0;
    rx(8'h01, 1'b0, 1'b1, 1'b0);
    chk("R8 even parity error", stat & 8'h48, 8'h08);
    par_odd = 1;
    rx(8'h01, 1'b0, 1'b1, 1'b1);
    chk("R8 odd parity ok accepted", stat & 8'h42, 8'h42);
    chk("R8 odd parity data", rx_buf, 8'h01);
    par_en = 0;
    cpu_rd_rxbuf = 1; @(negedge clk); cpu_rd_rxbuf = 0;
    rd_stat(); wr_stat(8'h00);
    chk("R2 error flags cleared", stat & 8'h78, 8'h00);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sw_clear();
    t_tx();
    t_race();
    t_rx();
    t_err();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule